// File: doc/BRIEF.md
# Serial Flash Controller Register Front-End

This block is the software-visible register file of a serial NOR flash controller. A 32-bit register bus (byte address, write strobe, write data, combinational read data) reaches seven registers: a status word, two identity words, a packed memory-operation word, an interrupt status word, an interrupt mask and a device select. On its other side it hands commands to a flash sequencer built elsewhere. That interface has a one-cycle start strobe, a 2-bit opcode and an argument. The sequencer answers with a busy level, illegal-access pulses, the flash status byte and the two identity bytes.

A single write to the memory-operation register carries both the command and its argument. The block accepts the command only when no earlier command is still in flight. It keeps its own write-in-progress flag from the moment it accepts a command until the sequencer's busy has risen and then dropped. Erase and write attempts on protected regions come back as pulses. These latch into sticky flags that software clears by writing ones, and the mask selects which flags drive the interrupt line. All command and status pins are plain levels or strobes. The block has no valid/ready stream, so no back-pressure applies; a command offered while busy is simply dropped.

Top module: `sfc_csr_front`

## Requirements
- R1: After reset, write-in-progress, interrupt flags, interrupt mask, start strobe and interrupt output are 0, and the device select reads 1.
- R2: A write to offset 0x0C while idle, with bits 1:0 equal to 1 (bulk erase), 2 (sector erase) or 3 (protect), raises start for exactly one cycle after the write edge, with opcode equal to bits 1:0. The argument is 0 for bulk erase, bits 17:8 for sector erase, and bits 12:8 zero-extended for protect (level in 11:8, top/bottom in 12; 0 removes protection).
- R3: A memory-operation write with bits 1:0 equal to 0 raises no start and leaves write-in-progress at 0.
- R4: Write-in-progress (status bit 0) becomes 1 at the accepting edge. It stays 1 while waiting for busy and while busy is high, and it returns to 0 at the first edge where busy is sampled low after having been high.
- R5: A memory-operation write while write-in-progress is 1 is dropped: no start, and the value read back from 0x0C does not change.
- R6: Interrupt status (0x10) bit 0 latches an illegal-erase pulse and bit 1 latches an illegal-write pulse. Writing 1 to a bit clears it, writing 0 leaves it, and a pulse in the same cycle as the clear keeps the bit set.
- R7: The interrupt output is 1 exactly when some status bit and the same bit of the mask (0x14, bit 0 erase, bit 1 write) are both 1.
- R8: Device select (0x18) is one-hot over three devices. Writes of 1, 2 or 4 are taken; any other value leaves it unchanged.
- R9: Status (0x00) returns write-in-progress in bit 0 and flash status bits 6:1 (write-enable latch bit 1, protect levels bits 2,3,4,6, top/bottom bit 5), with bit 7 and above 0. Offsets 0x04 and 0x08 return the silicon and read-ID bytes in bits 7:0. Unmapped offsets read 0.
- R10: Offset 0x0C returns the last accepted command: opcode in bits 1:0 and its argument placed back at bit 8, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| seq_start | output | 1 | One-cycle command launch |
| seq_opcode | output | 2 | Command code (1 bulk, 2 sector erase, 3 protect) |
| seq_arg | output | 10 | Sector number or protect value |
| seq_busy | input | 1 | Sequencer busy |
| seq_ill_erase | input | 1 | Illegal-erase pulse |
| seq_ill_write | input | 1 | Illegal-write pulse |
| flash_sr | input | 8 | Flash status byte |
| flash_sid | input | 8 | Silicon ID byte |
| flash_rdid | input | 8 | Read-ID byte |
| cs_onehot | output | 3 | One-hot device select |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its defaults: a 10-bit sector field, a 5-bit protect field placed at bit 8, and three devices. With a 10-bit field, sector 1023 is the top boundary, and junk written above bit 17 or above bit 12 shows whether field truncation is correct. The sequencer model raises busy two cycles after each start and holds it for three. This exposes the armed window before busy rises, the busy window, and the exact edge where write-in-progress falls.

// File: rtl/sfc_csr_pkg.sv
package sfc_csr_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_BULK = 2'd1,
    OP_SECT = 2'd2,
    OP_PROT = 2'd3
  } op_e;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_SID    = 8'h04;
  localparam logic [7:0] OFS_RDID   = 8'h08;
  localparam logic [7:0] OFS_MEMOP  = 8'h0C;
  localparam logic [7:0] OFS_ISR    = 8'h10;
  localparam logic [7:0] OFS_IMR    = 8'h14;
  localparam logic [7:0] OFS_CS     = 8'h18;

  localparam int IRQ_ERASE = 0;
  localparam int IRQ_WRITE = 1;
  localparam int NUM_IRQ   = 2;
endpackage

// File: rtl/sfc_op_launch.sv
module sfc_op_launch
  import sfc_csr_pkg::*;
#(
  parameter int SECT_W  = 10,
  parameter int PROT_W  = 5,
  parameter int ARG_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_op,
  input  logic [31:0]       wdata,
  input  logic              seq_busy,
  output logic              seq_start,
  output logic [1:0]        seq_opcode,
  output logic [SECT_W-1:0] seq_arg,
  output logic              wip,
  output logic [31:0]       op_word
);
  localparam int PAD_HI = 32 - ARG_LSB - SECT_W;
  localparam int PAD_LO = ARG_LSB - 2;

  typedef enum logic [1:0] {PH_IDLE, PH_ARMED, PH_RUN} phase_e;

  phase_e            phase_q;
  logic [1:0]        cmd_in;
  logic              accept;
  logic [SECT_W-1:0] arg_next;

  assign cmd_in = wdata[1:0];
  assign accept = wr_op && (phase_q == PH_IDLE) && (cmd_in != OP_NONE);

  always_comb begin
    case (cmd_in)
      OP_SECT: arg_next = wdata[ARG_LSB +: SECT_W];
      OP_PROT: arg_next = SECT_W'(wdata[ARG_LSB +: PROT_W]);
      default: arg_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      seq_start  <= 1'b0;
      seq_opcode <= 2'd0;
      seq_arg    <= '0;
    end else begin
      seq_start <= accept;
      if (accept) begin
        seq_opcode <= cmd_in;
        seq_arg    <= arg_next;
        phase_q    <= PH_ARMED;
      end else begin
        case (phase_q)
          PH_ARMED: if (seq_busy)  phase_q <= PH_RUN;
          PH_RUN:   if (!seq_busy) phase_q <= PH_IDLE;
          default:  phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign wip     = (phase_q != PH_IDLE);
  assign op_word = {{PAD_HI{1'b0}}, seq_arg, {PAD_LO{1'b0}}, seq_opcode};

  // R2: the launch strobe never lasts two cycles
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  // R4: a launched command is always covered by write-in-progress
  a_r4_start_has_wip: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> wip);
  // R5: an operation write during write-in-progress launches nothing
  a_r5_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && wip) |=> !seq_start);
  // R4: write-in-progress cannot drop while busy is high
  a_r4_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && seq_busy) |=> wip);
endmodule

// File: rtl/sfc_irq_unit.sv
module sfc_irq_unit #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [NBITS-1:0] clr_vec,
  input  logic             mask_wr,
  input  logic [NBITS-1:0] mask_vec,
  output logic [NBITS-1:0] isr,
  output logic [NBITS-1:0] imr,
  output logic             irq
);
  for (genvar b = 0; b < NBITS; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          isr[b] <= 1'b0;
      else if (set_vec[b]) isr[b] <= 1'b1;
      else if (clr_wr && clr_vec[b]) isr[b] <= 1'b0;
    end

    // R6: a flag stays set unless a one is written to its position
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (isr[b] && !(clr_wr && clr_vec[b])) |=> isr[b]);
    // R6: a pulse always leaves its flag set
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[b] |=> isr[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       imr <= '0;
    else if (mask_wr) imr <= mask_vec;
  end

  assign irq = |(isr & imr);

  // R7: no interrupt with an empty mask
  a_r7_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imr != '0));
endmodule

// File: rtl/sfc_cs_reg.sv
module sfc_cs_reg #(
  parameter int NUM_CS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [NUM_CS-1:0] wdata,
  output logic [NUM_CS-1:0] cs
);
  localparam logic [NUM_CS-1:0] CS_RESET = NUM_CS'(1);

  logic take;
  assign take = wr && ($countones(wdata) == 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cs <= CS_RESET;
    else if (take) cs <= wdata;
  end

  // R8: select register is always exactly one-hot
  a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs) == 1);
endmodule

// File: rtl/sfc_csr_front.sv
module sfc_csr_front
  import sfc_csr_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int SECT_W  = 10,
  parameter int PROT_W  = 5,
  parameter int ARG_LSB = 8,
  parameter int NUM_CS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              seq_start,
  output logic [1:0]        seq_opcode,
  output logic [SECT_W-1:0] seq_arg,
  input  logic              seq_busy,
  input  logic              seq_ill_erase,
  input  logic              seq_ill_write,
  input  logic [7:0]        flash_sr,
  input  logic [7:0]        flash_sid,
  input  logic [7:0]        flash_rdid,
  output logic [NUM_CS-1:0] cs_onehot,
  output logic              irq
);
  logic [7:0]         ofs;
  logic               wr_op, wr_isr, wr_imr, wr_cs;
  logic               wip;
  logic [31:0]        op_word;
  logic [NUM_IRQ-1:0] isr, imr, ill_vec;

  assign ofs    = 8'(reg_addr);
  assign wr_op  = reg_wr && (ofs == OFS_MEMOP);
  assign wr_isr = reg_wr && (ofs == OFS_ISR);
  assign wr_imr = reg_wr && (ofs == OFS_IMR);
  assign wr_cs  = reg_wr && (ofs == OFS_CS);

  assign ill_vec[IRQ_ERASE] = seq_ill_erase;
  assign ill_vec[IRQ_WRITE] = seq_ill_write;

  sfc_op_launch #(
    .SECT_W(SECT_W), .PROT_W(PROT_W), .ARG_LSB(ARG_LSB)
  ) u_launch (
    .clk(clk), .rst_n(rst_n), .wr_op(wr_op), .wdata(reg_wdata),
    .seq_busy(seq_busy), .seq_start(seq_start), .seq_opcode(seq_opcode),
    .seq_arg(seq_arg), .wip(wip), .op_word(op_word)
  );

  sfc_irq_unit #(.NBITS(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(ill_vec),
    .clr_wr(wr_isr), .clr_vec(reg_wdata[NUM_IRQ-1:0]),
    .mask_wr(wr_imr), .mask_vec(reg_wdata[NUM_IRQ-1:0]),
    .isr(isr), .imr(imr), .irq(irq)
  );

  sfc_cs_reg #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .wr(wr_cs),
    .wdata(reg_wdata[NUM_CS-1:0]), .cs(cs_onehot)
  );

  always_comb begin
    case (ofs)
      OFS_STATUS: reg_rdata = {25'd0, flash_sr[6:1], wip};
      OFS_SID:    reg_rdata = {24'd0, flash_sid};
      OFS_RDID:   reg_rdata = {24'd0, flash_rdid};
      OFS_MEMOP:  reg_rdata = op_word;
      OFS_ISR:    reg_rdata = 32'(isr);
      OFS_IMR:    reg_rdata = 32'(imr);
      OFS_CS:     reg_rdata = 32'(cs_onehot);
      default:    reg_rdata = 32'd0;
    endcase
  end

  // R3: an idle no-op write never starts the sequencer
  a_r3_noop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op && !wip && reg_wdata[1:0] == 2'd0) |=> !seq_start);
endmodule

// File: tb/sfc_csr_front_test.sv
module sfc_csr_front_test;
  localparam int SECT_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              seq_start;
  logic [1:0]        seq_opcode;
  logic [SECT_W-1:0] seq_arg;
  logic              seq_busy = 1'b0;
  logic              seq_ill_erase = 1'b0;
  logic              seq_ill_write = 1'b0;
  logic [7:0]        flash_sr = 8'h00;
  logic [7:0]        flash_sid = 8'h14;
  logic [7:0]        flash_rdid = 8'h19;
  logic [2:0]        cs_onehot;
  logic              irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [SECT_W+1:0] expq[$];

  always #10 clk = ~clk;

  sfc_csr_front uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_start(seq_start),
    .seq_opcode(seq_opcode), .seq_arg(seq_arg), .seq_busy(seq_busy),
    .seq_ill_erase(seq_ill_erase), .seq_ill_write(seq_ill_write),
    .flash_sr(flash_sr), .flash_sid(flash_sid), .flash_rdid(flash_rdid),
    .cs_onehot(cs_onehot), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic expect_op(input logic [1:0] op, input logic [SECT_W-1:0] arg);
    expq.push_back({op, arg});
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 50; i++) begin
      rd(5'h00, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  // sequencer model: busy rises two negedges after a start, lasts three
  initial begin
    forever begin
      @(negedge clk);
      if (seq_start) begin
        repeat (2) @(negedge clk);
        seq_busy = 1'b1;
        repeat (3) @(negedge clk);
        seq_busy = 1'b0;
      end
    end
  end

  // monitor: every start must match the oldest expected command (R2, R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && seq_start) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R5: unexpected start op=%0d arg=0x%0h expected none", seq_opcode, seq_arg);
        end else begin
          logic [SECT_W+1:0] e;
          e = expq.pop_front();
          if ({seq_opcode, seq_arg} !== e) begin
            fails++;
            $display("FAIL R2: start op/arg actual 0x%0h expected 0x%0h", {seq_opcode, seq_arg}, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, d); check("R1 wip", d, 32'h0);
    rd(5'h10, d); check("R1 isr", d, 32'h0);
    rd(5'h14, d); check("R1 imr", d, 32'h0);
    rd(5'h18, d); check("R1 cs", d, 32'h1);
    check("R1 irq", irq, 1'b0);
    check("R1 start", seq_start, 1'b0);

    // R9 read map
    flash_sr = 8'h7E;
    rd(5'h00, d); check("R9 status bits", d, 32'h7E);
    flash_sr = 8'hFF;
    rd(5'h00, d); check("R9 status mask", d, 32'h7E);
    flash_sr = 8'h02;
    rd(5'h04, d); check("R9 sid", d, 32'h14);
    rd(5'h08, d); check("R9 rdid", d, 32'h19);
    rd(5'h1C, d); check("R9 unmapped", d, 32'h0);

    // R2 R4 bulk erase with timed write-in-progress
    expect_op(2'd1, '0);
    wr(5'h0C, 32'h0003_FF01);
    peek(5'h00, d); check("R4 wip armed", d & 32'h1, 32'h1);
    repeat (5) @(negedge clk);
    peek(5'h00, d); check("R4 wip at busy fall", d & 32'h1, 32'h1);
    @(negedge clk);
    peek(5'h00, d); check("R4 wip cleared", d & 32'h1, 32'h0);
    rd(5'h0C, d); check("R10 bulk readback", d, 32'h1);

    // R2 sector erase at top sector, junk above field
    expect_op(2'd2, 10'h3FF);
    wr(5'h0C, 32'h0013_FF02);
    wait_idle();
    rd(5'h0C, d); check("R10 sector readback", d, 32'h0003_FF02);

    // R2 protect: only bits 12:8 survive
    expect_op(2'd3, 10'h01F);
    wr(5'h0C, 32'h0003_FF03);
    wait_idle();
    rd(5'h0C, d); check("R10 protect readback", d, 32'h0000_1F03);

    // R2 protect value zero removes protection
    expect_op(2'd3, 10'h000);
    wr(5'h0C, 32'h0000_0003);
    wait_idle();
    rd(5'h0C, d); check("R10 unprotect readback", d, 32'h3);

    // R3 no-op command
    wr(5'h0C, 32'h0000_0500);
    peek(5'h00, d); check("R3 wip stays 0", d & 32'h1, 32'h0);
    rd(5'h0C, d); check("R3 readback unchanged", d, 32'h3);

    // R5 command during write-in-progress dropped
    expect_op(2'd2, 10'd5);
    wr(5'h0C, 32'h0000_0502);
    wr(5'h0C, 32'h0000_0902);
    wait_idle();
    rd(5'h0C, d); check("R5 readback unchanged", d, 32'h0000_0502);

    // R6 R7 interrupt flags
    @(negedge clk); seq_ill_erase = 1'b1;
    @(negedge clk); seq_ill_erase = 1'b0;
    rd(5'h10, d); check("R6 erase latched", d, 32'h1);
    check("R7 masked off", irq, 1'b0);
    wr(5'h14, 32'h1);
    check("R7 irq on", irq, 1'b1);
    wr(5'h10, 32'h2);
    rd(5'h10, d); check("R6 write zero keeps", d, 32'h1);
    wr(5'h10, 32'h1);
    rd(5'h10, d); check("R6 w1c", d, 32'h0);
    check("R7 irq off", irq, 1'b0);
    @(negedge clk);
    seq_ill_write = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h2; reg_wr = 1'b1;
    @(negedge clk);
    seq_ill_write = 1'b0; reg_wr = 1'b0;
    rd(5'h10, d); check("R6 set beats clear", d, 32'h2);
    check("R7 other bit unmasked", irq, 1'b0);
    wr(5'h14, 32'h3);
    check("R7 write flag irq", irq, 1'b1);

    // R8 device select
    wr(5'h18, 32'h4); rd(5'h18, d); check("R8 take 4", d, 32'h4);
    check("R8 pin", cs_onehot, 3'h4);
    wr(5'h18, 32'h3); rd(5'h18, d); check("R8 ignore 3", d, 32'h4);
    wr(5'h18, 32'h0); rd(5'h18, d); check("R8 ignore 0", d, 32'h4);
    wr(5'h18, 32'h2); rd(5'h18, d); check("R8 take 2", d, 32'h2);

    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R2: missing starts actual %0d pending expected 0", expq.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule